// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt line and a fast interrupt line. Each line can be set up on its own to respond to a level or to an edge, with either sense. Software uses a small register bus with a write strobe, a read strobe, a byte address and 32-bit data to program the controller. The same bus lets software inspect and acknowledge pending events.

Every input passes through a two-flop synchroniser before it is examined. Edge-mode lines keep a sticky pending bit until software writes a one to that bit of the raw register. Level-mode lines show the current level, adjusted for polarity. Pending lines are gated by an enable mask. A per-line routing bit then sends each one to either the normal or the fast output, and both outputs are registered. For a two-level hierarchy, the normal output of one instance is tied to an input of another.

Top module: `trig_intc`

## Requirements
- R1: After reset, the enable, polarity, trigger-kind and routing registers read zero, and both outputs and the read data are low.
- R2: The masked status (byte offset 0x08) equals the raw register ANDed with the enable register (offset 0x00). An enable bit of 1 passes that line.
- R3: A polarity bit (offset 0x0C) of 1 selects active-high level or rising edge. A 0 selects active-low level or falling edge.
- R4: A trigger-kind bit (offset 0x10) of 1 makes the line edge-sensitive. A detected edge sets a raw bit (offset 0x04), and that bit stays set after the input returns.
- R5: Writing 1 to a raw-register bit clears that line's latched edge, and writing 0 leaves it unchanged. If a new edge is detected in the same cycle as the clear, the bit stays set.
- R6: For a level-sensitive line, the raw bit follows the polarity-adjusted input and is never sticky. Writing ones to it has no effect.
- R7: A level change on an input becomes visible in a raw read issued two clock edges after the change is sampled. Reads issued at the first two edges still return the old value.
- R8: The normal output rises one cycle after any masked-status bit whose routing bit (offset 0x14) is 0 is set, and falls one cycle after none is.
- R9: The fast output rises one cycle after any masked-status bit whose routing bit is 1 is set, and falls one cycle after none is.
- R10: A read strobe returns the addressed register on the read data one cycle later, and the read data holds between reads. Writes to offsets 0x00, 0x0C, 0x10 and 0x14 read back unchanged.
- R11: Reads of offsets other than 0x00 to 0x14 return zero. Writes to those offsets, or to the status offset 0x08, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Asynchronous interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
Directed phases use steady levels under both polarities to separate level handling from edge handling. They then toggle lines in edge mode and return them to idle, which shows that the raw bit is sticky. A clear is aligned to the exact cycle of a fresh edge to show which one wins. Back-to-back reads after a single input change pin the synchroniser latency. Split routing masks show that each line reaches only its chosen output. A long random phase mixes register writes, clears and input toggles against the cycle model, which catches wrong combinations of polarity, kind, mask and routing.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;

  localparam int unsigned OFS_ENABLE = 32'h00;
  localparam int unsigned OFS_RAW    = 32'h04;
  localparam int unsigned OFS_PEND   = 32'h08;
  localparam int unsigned OFS_POLAR  = 32'h0C;
  localparam int unsigned OFS_KIND   = 32'h10;
  localparam int unsigned OFS_ROUTE  = 32'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_RAW,
    SEL_PEND,
    SEL_POLAR,
    SEL_KIND,
    SEL_ROUTE
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [31:0] byte_addr);
    reg_sel_e s;
    case (byte_addr)
      OFS_ENABLE: s = SEL_ENABLE;
      OFS_RAW:    s = SEL_RAW;
      OFS_PEND:   s = SEL_PEND;
      OFS_POLAR:  s = SEL_POLAR;
      OFS_KIND:   s = SEL_KIND;
      OFS_ROUTE:  s = SEL_ROUTE;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Polarity-adjusted level of one line.
  function automatic logic level_hit(input logic cur, input logic act_high);
    return act_high ? cur : ~cur;
  endfunction

  // One-cycle edge event for one line in edge mode.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic act_high, input logic is_edge);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return is_edge & (act_high ? rise : fall);
  endfunction

  // Next value of a sticky edge latch: a fresh event beats a clear.
  function automatic logic held_next(input logic held, input logic clr,
                                     input logic evt, input logic is_edge);
    return is_edge & ((held & ~clr) | evt);
  endfunction

endpackage

// File: rtl/trig_intc_sync.sv
module trig_intc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/trig_intc_detect.sv
module trig_intc_detect
  import trig_intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] line_s,
  input  logic [NSRC-1:0] act_high,
  input  logic [NSRC-1:0] is_edge,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] edge_evt,
  output logic [NSRC-1:0] held_q,
  output logic [NSRC-1:0] raw_vec
);

  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_s;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_line
    logic lvl;
    assign lvl         = level_hit(line_s[i], act_high[i]);
    assign edge_evt[i] = edge_hit(line_s[i], prev_q[i], act_high[i], is_edge[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) held_q[i] <= 1'b0;
      else        held_q[i] <= held_next(held_q[i], clr_vec[i], edge_evt[i], is_edge[i]);
    end

    assign raw_vec[i] = is_edge[i] ? held_q[i] : lvl;
  end

endmodule

// File: rtl/trig_intc_regs.sv
module trig_intc_regs
  import trig_intc_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] raw_vec,
  input  logic [NSRC-1:0] pend_vec,
  output logic [NSRC-1:0] enable_q,
  output logic [NSRC-1:0] polar_q,
  output logic [NSRC-1:0] kind_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] rdata
);

  reg_sel_e        sel;
  logic [NSRC-1:0] rd_mux;

  assign sel = decode_sel(32'(addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      polar_q  <= '0;
      kind_q   <= '0;
      route_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_ENABLE: enable_q <= wdata;
        SEL_POLAR:  polar_q  <= wdata;
        SEL_KIND:   kind_q   <= wdata;
        SEL_ROUTE:  route_q  <= wdata;
        default:    ;
      endcase
    end
  end

  assign clr_vec = (wr_en && sel == SEL_RAW) ? wdata : '0;

  always_comb begin
    case (sel)
      SEL_ENABLE: rd_mux = enable_q;
      SEL_RAW:    rd_mux = raw_vec;
      SEL_PEND:   rd_mux = pend_vec;
      SEL_POLAR:  rd_mux = polar_q;
      SEL_KIND:   rd_mux = kind_q;
      SEL_ROUTE:  rd_mux = route_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/trig_intc.sv
module trig_intc
  import trig_intc_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_out,
  output logic            fiq_out
);

  logic [NSRC-1:0] line_s;
  logic [NSRC-1:0] enable_q;
  logic [NSRC-1:0] polar_q;
  logic [NSRC-1:0] kind_q;
  logic [NSRC-1:0] route_q;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] edge_evt;
  logic [NSRC-1:0] held_q;
  logic [NSRC-1:0] raw_vec;
  logic [NSRC-1:0] pend_vec;
  logic            want_irq;
  logic            want_fiq;

  trig_intc_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (src_in),
    .dout (line_s)
  );

  trig_intc_detect #(.NSRC(NSRC)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_s  (line_s),
    .act_high(polar_q),
    .is_edge (kind_q),
    .clr_vec (clr_vec),
    .edge_evt(edge_evt),
    .held_q  (held_q),
    .raw_vec (raw_vec)
  );

  assign pend_vec = raw_vec & enable_q;

  trig_intc_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .raw_vec (raw_vec),
    .pend_vec(pend_vec),
    .enable_q(enable_q),
    .polar_q (polar_q),
    .kind_q  (kind_q),
    .route_q (route_q),
    .clr_vec (clr_vec),
    .rdata   (rdata)
  );

  assign want_irq = |(pend_vec & ~route_q);
  assign want_fiq = |(pend_vec & route_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= want_irq;
      fiq_out <= want_fiq;
    end
  end

endmodule

// File: rtl/trig_intc_chk.sv
module trig_intc_chk #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NSRC-1:0] pend_vec,
  input logic [NSRC-1:0] route_q,
  input logic [NSRC-1:0] enable_q,
  input logic [NSRC-1:0] polar_q,
  input logic [NSRC-1:0] kind_q,
  input logic [NSRC-1:0] edge_evt,
  input logic [NSRC-1:0] clr_vec,
  input logic [NSRC-1:0] held_q,
  input logic            irq_out,
  input logic            fiq_out
);

  // R8
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~route_q) != '0) |=> irq_out);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~route_q) == '0) |=> !irq_out);

  // R9
  fiq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & route_q) != '0) |=> fiq_out);

  // R9
  fiq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & route_q) == '0) |=> !fiq_out);

  // R5
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((held_q & $past(edge_evt)) == $past(edge_evt)));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~edge_evt) != '0) |=> ((held_q & $past(clr_vec & ~edge_evt)) == '0));

  // R6
  level_not_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q != {NSRC{1'b1}}) |=> ((held_q & ~$past(kind_q)) == '0));

  // R11
  pend_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h08)) |=>
      ($stable(enable_q) && $stable(polar_q) && $stable(kind_q) && $stable(route_q)));

endmodule

bind trig_intc trig_intc_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .pend_vec(pend_vec),
  .route_q (route_q),
  .enable_q(enable_q),
  .polar_q (polar_q),
  .kind_q  (kind_q),
  .edge_evt(edge_evt),
  .clr_vec (clr_vec),
  .held_q  (held_q),
  .irq_out (irq_out),
  .fiq_out (fiq_out)
);

// File: tb/trig_intc_bench.sv
module trig_intc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;
  logic        fiq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  trig_intc u_trig_intc (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  // Behavioural cycle model
  bit [31:0] in_hist[$];
  bit [31:0] seen_prev, ref_held, ref_en, ref_hi, ref_kind, ref_route, ref_rd;
  bit        ref_irq, ref_fiq;

  function automatic bit [31:0] line_now();
    return in_hist.size() >= 2 ? in_hist[1] : 32'h0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      in_hist = {32'h0, 32'h0};
      seen_prev = 0; ref_held = 0; ref_en = 0; ref_hi = 0; ref_kind = 0;
      ref_route = 0; ref_rd = 0; ref_irq = 0; ref_fiq = 0;
    end else begin
      bit [31:0] cur, raw, pend, evt, clr;
      cur = line_now();
      raw = 0; evt = 0;
      for (int i = 0; i < 32; i++) begin
        bit active;
        active = ref_hi[i] ? cur[i] : !cur[i];
        if (ref_kind[i]) begin
          raw[i] = ref_held[i];
          if (ref_hi[i] && cur[i] && !seen_prev[i]) evt[i] = 1;
          if (!ref_hi[i] && !cur[i] && seen_prev[i]) evt[i] = 1;
        end else begin
          raw[i] = active;
        end
      end
      pend = raw & ref_en;
      ref_irq = (pend & ~ref_route) != 0;
      ref_fiq = (pend & ref_route) != 0;
      if (rd_en) begin
        case (addr)
          8'h00: ref_rd = ref_en;
          8'h04: ref_rd = raw;
          8'h08: ref_rd = pend;
          8'h0C: ref_rd = ref_hi;
          8'h10: ref_rd = ref_kind;
          8'h14: ref_rd = ref_route;
          default: ref_rd = 0;
        endcase
      end
      clr = (wr_en && addr == 8'h04) ? wdata : 0;
      ref_held = ref_kind & ((ref_held & ~clr) | evt);
      if (wr_en) begin
        if (addr == 8'h00) ref_en = wdata;
        if (addr == 8'h0C) ref_hi = wdata;
        if (addr == 8'h10) ref_kind = wdata;
        if (addr == 8'h14) ref_route = wdata;
      end
      seen_prev = cur;
      in_hist.push_front(src_in);
      void'(in_hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Compare every clock, 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
    if (rst_n) begin
      check(irq_out == ref_irq, "R8 irq_out", 32'(irq_out), 32'(ref_irq));
      check(fiq_out == ref_fiq, "R9 fiq_out", 32'(fiq_out), 32'(ref_fiq));
      check(rdata == ref_rd, "R10 rdata", rdata, ref_rd);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] msk, input logic [31:0] exp, input string tag);
    rd_en = 1; addr = a;
    step();
    rd_en = 0;
    check((rdata & msk) == exp, tag, rdata & msk, exp);
  endtask

  task automatic rd_model(input logic [7:0] a, input string tag);
    rd_en = 1; addr = a;
    step();
    rd_en = 0;
    check(rdata == ref_rd, tag, rdata, ref_rd);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1;
    // R1: reset state
    check(irq_out == 0 && fiq_out == 0, "R1 outputs low", {irq_out, fiq_out}, 0);
    check(rdata == 0, "R1 rdata", rdata, 0);
    rd_lit(8'h00, '1, 0, "R1 enable");
    rd_lit(8'h0C, '1, 0, "R1 polarity");
    rd_lit(8'h10, '1, 0, "R1 kind");
    rd_lit(8'h14, '1, 0, "R1 route");

    // R10: register map read-back
    wr(8'h00, 32'hA5A5_0F0F); rd_lit(8'h00, '1, 32'hA5A5_0F0F, "R10 enable");
    wr(8'h0C, 32'h1234_5678); rd_lit(8'h0C, '1, 32'h1234_5678, "R10 polarity");
    wr(8'h10, 32'h0F0F_0000); rd_lit(8'h10, '1, 32'h0F0F_0000, "R10 kind");
    wr(8'h14, 32'h8000_0001); rd_lit(8'h14, '1, 32'h8000_0001, "R10 route");
    rd_lit(8'h14, '1, 32'h8000_0001, "R10 route reread");

    // R11: undefined offsets and status write
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    rd_lit(8'h00, '1, 32'hA5A5_0F0F, "R11 enable kept");
    rd_lit(8'h0C, '1, 32'h1234_5678, "R11 polarity kept");
    rd_lit(8'h10, '1, 32'h0F0F_0000, "R11 kind kept");
    rd_lit(8'h14, '1, 32'h8000_0001, "R11 route kept");
    rd_lit(8'h18, '1, 0, "R11 undefined read");
    rd_lit(8'hFC, '1, 0, "R11 undefined high read");

    // R3/R6: level mode under both polarities
    wr(8'h10, 0); wr(8'h14, 0); wr(8'h0C, 0); wr(8'h00, 32'hFFFF_FFFF);
    src_in = 32'h0000_00FF; idle(4);
    rd_lit(8'h04, '1, 32'hFFFF_FF00, "R3 active-low raw");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_lit(8'h04, '1, 32'h0000_00FF, "R3 active-high raw");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_lit(8'h04, '1, 32'h0000_00FF, "R6 level ignores clear");
    src_in = 0; idle(4);
    rd_lit(8'h04, '1, 0, "R6 level not sticky");
    // R2: masked status
    src_in = 32'h0000_0F0F; wr(8'h00, 32'h0000_00FF); idle(3);
    rd_lit(8'h08, '1, 32'h0000_000F, "R2 status gated");
    check(irq_out == 1 && fiq_out == 0, "R8 irq from level", {irq_out, fiq_out}, 2);

    // R7: synchroniser latency, active-low on bit 0
    wr(8'h0C, 0); src_in = 32'h1; idle(4);
    src_in = 32'h0; rd_en = 1; addr = 8'h04;
    step(); check(rdata[0] == 0, "R7 edge 1 old", rdata, 0);
    step(); check(rdata[0] == 0, "R7 edge 2 old", rdata, 0);
    step(); check(rdata[0] == 1, "R7 edge 3 new", rdata, 1);
    rd_en = 0;

    // R4: edge mode sticky
    src_in = 0; idle(3);
    wr(8'h0C, 32'h0000_FFFF); wr(8'h10, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); idle(2);
    rd_lit(8'h04, '1, 0, "R4 edge idle");
    src_in = 32'h0001_0001; idle(4);
    rd_lit(8'h04, '1, 32'h0000_0001, "R4 rising latched");
    src_in = 0; idle(4);
    rd_lit(8'h04, '1, 32'h0001_0001, "R4 falling latched, rising sticky");
    // R5: clear, zero write, same-cycle race
    wr(8'h04, 0);
    rd_lit(8'h04, '1, 32'h0001_0001, "R5 zero write no effect");
    wr(8'h04, 32'h0000_0001);
    rd_lit(8'h04, '1, 32'h0001_0000, "R5 one clears");
    wr(8'h04, 32'h0001_0000); idle(1);
    src_in = 32'h0000_0002; step(); step();
    wr(8'h04, 32'h0000_0002);
    rd_lit(8'h04, 32'h0000_0002, 32'h0000_0002, "R5 new edge beats clear");

    // R8/R9: routing split
    wr(8'h04, '1); wr(8'h10, 0); wr(8'h0C, '1); wr(8'h00, '1);
    wr(8'h14, 32'h0000_0002); src_in = 32'h0000_0002; idle(4);
    check(irq_out == 0 && fiq_out == 1, "R9 fast only", {irq_out, fiq_out}, 1);
    src_in = 32'h0000_0003; idle(4);
    check(irq_out == 1 && fiq_out == 1, "R8 both", {irq_out, fiq_out}, 3);
    wr(8'h00, 32'h0000_0001); idle(1);
    check(irq_out == 1 && fiq_out == 0, "R9 fast masked", {irq_out, fiq_out}, 2);
    rd_model(8'h08, "R2 status model");

    // Random phase against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) src_in = src_in ^ (32'h1 << $urandom_range(0, 31));
      else if (r < 5) begin
        wr_en = 1; addr = 8'($urandom_range(0, 7) * 4); wdata = $urandom();
      end else if (r < 7) begin
        rd_en = 1; addr = 8'($urandom_range(0, 7) * 4);
      end
      step();
      wr_en = 0; rd_en = 0;
    end
    rd_model(8'h04, "R4 random raw");
    rd_model(8'h08, "R2 random status");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule